// File: doc/BRIEF.md
# Layered Video Plane Priority Compositor

This block picks the colour shown at every pixel from a stack of display layers. On each pixel clock it takes one candidate colour code from each of a set of sprite layers (with a valid flag per layer), one from the tile/pattern layer, the backdrop colour register, a flag that says an external video source is present, a flag that marks the active picture area, and the current display mode. It registers a single 4-bit colour index. It also registers a select bit that tells the downstream video mixer to show the external picture instead.

The stack has four tiers. The sprite layers sit nearest the viewer, and a lower layer number sits in front. The pattern layer sits behind them. The backdrop comes next, and it alone fills the border around the active area. External video sits at the back. A code of zero is see-through at every tier. In the forty-column text mode the sprite tier takes no part. Integrators feed the block from the sprite and pattern fetch pipelines and pass its outputs to the DAC/mixer stage.

Top module: `plane_compositor`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `color_out` = 0 and `ext_sel` = 0.
- R2: In the active area and outside text mode, the output is the code of the lowest-numbered sprite layer whose valid bit is 1 and whose code is non-zero. Layer k occupies bits [4k+3:4k] of `spr_code`.
- R3: A sprite layer whose valid bit is 0, or whose code is 0, is transparent. It never wins, even if its code is non-zero.
- R4: In the active area, when every sprite layer is transparent and `pat_code` is non-zero, the output is `pat_code`.
- R5: In the active area, when the sprites and the pattern are all transparent, the output is `backdrop`.
- R6: When `in_active` is 0 (border), the output is `backdrop`, whatever the sprite and pattern inputs hold.
- R7: When `mode` is 2'b11 (forty-column text), every sprite layer is ignored. The output is the pattern code if non-zero, else the backdrop. The other mode codes (2'b00, 2'b01, 2'b10) allow sprites.
- R8: `ext_sel` is 1 exactly when the registered colour is 0 and `ext_present` was 1 in the same input cycle. `ext_present` never changes `color_out`.
- R9: Outputs change only at a rising clock edge, one cycle after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_code | input | NUM_LAYERS*4 | Packed sprite layer colour codes, layer k at [4k+3:4k] |
| spr_valid | input | NUM_LAYERS | Per-layer sprite present flag |
| pat_code | input | 4 | Pattern layer colour code |
| backdrop | input | 4 | Backdrop colour register value |
| ext_present | input | 1 | External video source available |
| in_active | input | 1 | Pixel lies inside the active picture |
| mode | input | 2 | Display mode, 2'b11 = text |
| color_out | output | 4 | Registered final colour index |
| ext_sel | output | 1 | Registered request to show external video |

## Verification
The bench aims at priority mistakes. It places a valid sprite with code 0 in front of an opaque one, so that a design that treats valid alone as opaque would output 0. It places opaque sprites on layer 0 and on the last layer together, to catch an encoder that favours the high index. It drives border pixels with opaque sprites and patterns, to catch a design that lets them bleed into the border. It drives text-mode pixels with opaque sprites, to catch sprites that leak through in that mode. It also tests a zero backdrop with and without external video, to catch a select bit that ignores either condition. Random layer mixes are checked against a bench model that scans the layers in order. Each vector also checks that the output holds its old value until the clock edge.

// File: rtl/plane_comp_pkg.sv
package plane_comp_pkg;
  typedef enum logic [1:0] {
    MODE_TILE    = 2'b00,
    MODE_BITMAP  = 2'b01,
    MODE_BLOCK   = 2'b10,
    MODE_TEXT40  = 2'b11
  } disp_mode_e;
endpackage

// File: rtl/plane_sprite_arbiter.sv
// Binary find-first tree: the left (lower-numbered) child always wins.
module plane_sprite_arbiter #(
  parameter int NUM_LAYERS = 32,
  parameter int CW         = 4
) (
  input  logic [NUM_LAYERS*CW-1:0] spr_code,
  input  logic [NUM_LAYERS-1:0]    spr_valid,
  output logic                     win_hit,
  output logic [CW-1:0]            win_code
);
  localparam int LVL   = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 0;
  localparam int PAD   = 1 << LVL;
  localparam int NODES = 2 * PAD - 1;

  logic          node_hit  [NODES];
  logic [CW-1:0] node_code [NODES];

  genvar j;
  generate
    for (j = 0; j < PAD; j++) begin : g_leaf
      if (j < NUM_LAYERS) begin : g_real
        assign node_hit[PAD-1+j]  = spr_valid[j] && (spr_code[j*CW +: CW] != '0);
        assign node_code[PAD-1+j] = spr_code[j*CW +: CW];
      end else begin : g_pad
        assign node_hit[PAD-1+j]  = 1'b0;
        assign node_code[PAD-1+j] = '0;
      end
    end
    for (j = 0; j < PAD - 1; j++) begin : g_node
      assign node_hit[j]  = node_hit[2*j+1] | node_hit[2*j+2];
      assign node_code[j] = node_hit[2*j+1] ? node_code[2*j+1] : node_code[2*j+2];
    end
  endgenerate

  assign win_hit  = node_hit[0];
  assign win_code = node_code[0];
endmodule

// File: rtl/plane_tier_select.sv
module plane_tier_select
  import plane_comp_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          spr_hit,
  input  logic [CW-1:0] spr_win,
  input  logic [CW-1:0] pat_code,
  input  logic [CW-1:0] backdrop,
  input  logic          in_active,
  input  logic [1:0]    mode,
  output logic [CW-1:0] next_color
);
  logic sprites_on;
  assign sprites_on = (mode != MODE_TEXT40);

  always_comb begin
    if (!in_active)                next_color = backdrop;
    else if (sprites_on && spr_hit) next_color = spr_win;
    else if (pat_code != '0)       next_color = pat_code;
    else                           next_color = backdrop;
  end
endmodule

// File: rtl/plane_compositor.sv
module plane_compositor
  import plane_comp_pkg::*;
#(
  parameter int NUM_LAYERS = 32,
  parameter int CW         = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_LAYERS*CW-1:0] spr_code,
  input  logic [NUM_LAYERS-1:0]    spr_valid,
  input  logic [CW-1:0]            pat_code,
  input  logic [CW-1:0]            backdrop,
  input  logic                     ext_present,
  input  logic                     in_active,
  input  logic [1:0]               mode,
  output logic [CW-1:0]            color_out,
  output logic                     ext_sel
);
  logic          spr_hit;
  logic [CW-1:0] spr_win;
  logic [CW-1:0] next_color;

  plane_sprite_arbiter #(.NUM_LAYERS(NUM_LAYERS), .CW(CW)) arb_i (
    .spr_code (spr_code),
    .spr_valid(spr_valid),
    .win_hit  (spr_hit),
    .win_code (spr_win)
  );

  plane_tier_select #(.CW(CW)) sel_i (
    .spr_hit   (spr_hit),
    .spr_win   (spr_win),
    .pat_code  (pat_code),
    .backdrop  (backdrop),
    .in_active (in_active),
    .mode      (mode),
    .next_color(next_color)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      color_out <= '0;
      ext_sel   <= 1'b0;
    end else begin
      color_out <= next_color;
      ext_sel   <= (next_color == '0) && ext_present;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (color_out == '0 && !ext_sel));

  a_r8_ext_only_on_zero: assert property (@(posedge clk) disable iff (rst)
    ext_sel |-> (color_out == '0));

  a_r6_border_backdrop: assert property (@(posedge clk) disable iff (rst)
    !in_active |=> (color_out == $past(backdrop)));

  a_r7_text_no_sprites: assert property (@(posedge clk) disable iff (rst)
    (in_active && mode == MODE_TEXT40) |=>
      (color_out == (($past(pat_code) != '0) ? $past(pat_code) : $past(backdrop))));

  a_r4_pattern_shows: assert property (@(posedge clk) disable iff (rst)
    (in_active && spr_valid == '0 && pat_code != '0) |=> (color_out == $past(pat_code)));

  a_r8_ext_needs_present: assert property (@(posedge clk) disable iff (rst)
    !ext_present |=> !ext_sel);
endmodule

// File: tb/plane_compositor_tb.sv
module plane_compositor_tb_top;
  localparam int N  = 32;
  localparam int CW = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [N*CW-1:0] spr_code;
  logic [N-1:0]    spr_valid;
  logic [CW-1:0]   pat_code, backdrop;
  logic            ext_present, in_active;
  logic [1:0]      mode;
  logic [CW-1:0]   color_out;
  logic            ext_sel;

  int n_vec = 0;
  int n_bad = 0;
  logic [CW-1:0] prev_color = '0;
  logic          prev_ext   = 1'b0;

  always #10 clk = ~clk;

  plane_compositor #(.NUM_LAYERS(N), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .spr_code(spr_code), .spr_valid(spr_valid),
    .pat_code(pat_code), .backdrop(backdrop), .ext_present(ext_present),
    .in_active(in_active), .mode(mode), .color_out(color_out), .ext_sel(ext_sel)
  );

  function automatic logic [CW-1:0] ref_color();
    if (!in_active) return backdrop;
    if (mode != 2'b11)
      for (int k = 0; k < N; k++)
        if (spr_valid[k] && spr_code[k*CW +: CW] != 0) return spr_code[k*CW +: CW];
    if (pat_code != 0) return pat_code;
    return backdrop;
  endfunction

  task automatic check(input string req, input logic [CW-1:0] got_c, input logic got_e,
                       input logic [CW-1:0] exp_c, input logic exp_e);
    n_vec++;
    if (got_c !== exp_c || got_e !== exp_e) begin
      n_bad++;
      $display("FAIL %s: color=%0h ext=%0b expected color=%0h ext=%0b",
               req, got_c, got_e, exp_c, exp_e);
    end
  endtask

  // Drive at negedge; mid-cycle the old output must hold (R9); next negedge the new one.
  task automatic apply(input string req);
    logic [CW-1:0] ec;
    logic ee;
    ec = ref_color();
    ee = (ec == 0) && ext_present;
    #5 check({req, "/R9 hold"}, color_out, ext_sel, prev_color, prev_ext);
    @(negedge clk);
    check(req, color_out, ext_sel, ec, ee);
    prev_color = ec;
    prev_ext   = ee;
  endtask

  task automatic clear_inputs();
    spr_code = '0; spr_valid = '0; pat_code = '0; backdrop = '0;
    ext_present = 1'b0; in_active = 1'b1; mode = 2'b00;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: color=%0h ext=%0b expected completion", color_out, ext_sel);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    clear_inputs();
    spr_valid = '1; spr_code = {N{4'h7}}; pat_code = 4'h3; backdrop = 4'h9; ext_present = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", color_out, ext_sel, 4'h0, 1'b0);
    clear_inputs();
    rst = 1'b0;
    prev_color = '0; prev_ext = 1'b0;

    // R5/R8: everything transparent, zero backdrop, external present
    ext_present = 1'b1;
    apply("R5 R8 all clear ext");
    // R8: ext_present must not change the colour when backdrop opaque
    backdrop = 4'hC;
    apply("R8 opaque backdrop blocks ext");
    ext_present = 1'b0; backdrop = 4'h0;
    apply("R8 no ext source");
    // R4: pattern over backdrop
    backdrop = 4'h4; pat_code = 4'hE;
    apply("R4 pattern");
    // R2: last layer alone, then with layer 0
    spr_valid[N-1] = 1'b1; spr_code[(N-1)*CW +: CW] = 4'h5;
    apply("R2 last layer only");
    spr_valid[0] = 1'b1; spr_code[0 +: CW] = 4'hA;
    apply("R2 layer0 over last");
    // R3: layer 0 valid with code 0, layer 0 invalid with code set
    spr_code[0 +: CW] = 4'h0; spr_valid[3] = 1'b1; spr_code[3*CW +: CW] = 4'hB;
    apply("R3 valid zero code skipped");
    spr_valid[0] = 1'b0; spr_code[0 +: CW] = 4'hF;
    apply("R3 invalid code skipped");
    // R7: text mode ignores sprites
    mode = 2'b11;
    apply("R7 text pattern");
    pat_code = 4'h0;
    apply("R7 text backdrop");
    backdrop = 4'h0; ext_present = 1'b1;
    apply("R7 R8 text ext");
    // R6: border with opaque sprites and pattern
    mode = 2'b01; in_active = 1'b0; pat_code = 4'h2; backdrop = 4'h6;
    apply("R6 border");
    backdrop = 4'h0;
    apply("R6 R8 border zero backdrop");
    // boundary toggling
    for (int b = 0; b < 6; b++) begin
      in_active = b[0];
      apply("R6 boundary toggle");
    end

    // Random mixes
    for (int v = 0; v < 2000; v++) begin
      for (int k = 0; k < N; k++) begin
        spr_valid[k] = ($urandom_range(0, 9) < 2);
        spr_code[k*CW +: CW] = ($urandom_range(0, 3) == 0) ? 4'h0 : CW'($urandom_range(1, 15));
      end
      pat_code    = ($urandom_range(0, 2) == 0) ? 4'h0 : CW'($urandom_range(0, 15));
      backdrop    = ($urandom_range(0, 2) == 0) ? 4'h0 : CW'($urandom_range(0, 15));
      ext_present = $urandom_range(0, 1) == 1;
      in_active   = $urandom_range(0, 4) != 0;
      mode        = 2'($urandom_range(0, 3));
      apply("R2 R3 R4 R5 R6 R7 R8 random");
    end

    // R1: reset from a non-zero output
    clear_inputs();
    backdrop = 4'hD;
    apply("R5 pre-reset");
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", color_out, ext_sel, 4'h0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule